// File: doc/BRIEF.md
# Sixteen-Bit Timer with Capture and Reload

This block is a 16-bit up-counter paired with a 16-bit auxiliary register that serves either as the reload value or as the capture target. A control byte chooses the counting source, the mode and whether an external trigger pin takes part. In reload mode a rollover, or optionally a falling edge on the trigger pin, loads the counter from the auxiliary register. In capture mode the counter wraps freely, and a trigger edge copies the live count into the auxiliary register.

Two sticky flags live in the control byte. The rollover flag records a counter wrap. The trigger flag records a trigger event. Either flag raises the single interrupt line, and software clears the flags by writing the control byte. Both pins pass through a two-flop synchronizer, and only synchronized falling edges count. Setting either serial-clock bit hands the timer over to baud-rate use, which this block does not implement. In that state the timer holds still and ignores triggers.

Top module: `tmr16_capreload`

## Requirements
- R1: After reset every register reads 0x00 and irq_o is low.
- R2: Control bit 0 is run, bit 4 and bit 5 are the serial clock selects. With run clear, or with bit 4 or bit 5 set, the counter holds its value and trigger edges change nothing.
- R3: Control bit 1 picks the count source. At 0 the counter advances once for each clock in which tick_i is high. At 1 it advances once for each synchronized falling edge of cnt_pin_i.
- R4: With control bit 2 clear (reload mode), an increment from 0xFFFF loads the counter from the auxiliary register and sets the rollover flag in control bit 7.
- R5: In reload mode with control bit 3 set, a falling edge on trig_pin_i loads the counter from the auxiliary register and sets the trigger flag in control bit 6. A pin that goes low before clock edge k takes effect at edge k+2.
- R6: With control bit 2 set (capture mode), an increment from 0xFFFF gives 0x0000 and sets the rollover flag. The auxiliary register keeps its value.
- R7: In capture mode with control bit 3 set, a trigger falling edge copies the count held before that edge into the auxiliary register and sets the trigger flag. Counting goes on without a break.
- R8: With control bit 3 clear, trigger edges leave the counter, the auxiliary register and bit 6 unchanged.
- R9: When a rollover and a trigger reload fall in the same cycle in reload mode, a single load from the auxiliary register takes place and both flags are set.
- R10: Only a control write clears a flag. A hardware set in the same cycle as a clearing write leaves the flag set.
- R11: irq_o is high exactly when bit 6 or bit 7 of the control byte is set.
- R12: Register addresses are 0 control, 1 count low, 2 count high, 3 auxiliary low, 4 auxiliary high. Other addresses read 0x00. rd_data_o shows the addressed register in the same cycle. A write to a count or auxiliary byte replaces that byte, and the register it belongs to takes no hardware update in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Machine-cycle count enable |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| trig_pin_i | input | 1 | External trigger pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data for rd_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are a trigger edge that reaches the counter in the very cycle it rolls over, and a flag-clearing write that lands in the cycle hardware sets that flag. The synchronizer delay makes both depend on precise timing. The stimulus preloads the counter a few counts below 0xFFFF and then sweeps the cycle at which the trigger pin drops, or the cycle at which the clearing write is issued, across a window. One run of each sweep is bound to coincide with the wrap. The model is compared with the design on every clock, and the read address cycles through all registers.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NBYTES = CNT_W / BYTE_W;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_OFF,
    MODE_BAUD,
    MODE_RELOAD,
    MODE_CAPTURE
  } tmr_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd3;

  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_SRC   = 1;
  localparam int unsigned B_CAPM  = 2;
  localparam int unsigned B_EXEN  = 3;
  localparam int unsigned B_RXCK  = 4;
  localparam int unsigned B_TXCK  = 5;
  localparam int unsigned B_EXTF  = 6;
  localparam int unsigned B_OVF   = 7;
endpackage

// File: rtl/tmr16_fall_det.sv
module tmr16_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  assign sync_d[0] = pin_i;
  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    assign sync_d[g] = sync_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];

  // R5
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [BYTE_W-1:0] wd_i,
  input  logic             set_ovf_i,
  input  logic             set_ext_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output tmr_mode_e        mode_o
);
  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] ctrl_d;
  logic              ctrl_en;

  always_comb begin
    ctrl_d = wr_i ? wd_i : ctrl_q;
    ctrl_d[B_OVF]  = ctrl_d[B_OVF]  | set_ovf_i;
    ctrl_d[B_EXTF] = ctrl_d[B_EXTF] | set_ext_i;
    ctrl_en = wr_i | set_ovf_i | set_ext_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_comb begin
    if (!ctrl_q[B_RUN])                       mode_o = MODE_OFF;
    else if (ctrl_q[B_RXCK] | ctrl_q[B_TXCK]) mode_o = MODE_BAUD;
    else if (ctrl_q[B_CAPM])                  mode_o = MODE_CAPTURE;
    else                                      mode_o = MODE_RELOAD;
  end

  assign ctrl_o = ctrl_q;

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf_i |=> ctrl_q[B_OVF]);
  // R10
  ext_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ext_i |=> ctrl_q[B_EXTF]);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_OVF] && !wr_i) |=> ctrl_q[B_OVF]);
  // R10
  ext_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_EXTF] && !wr_i) |=> ctrl_q[B_EXTF]);
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode_i,
  input  logic              src_ext_i,
  input  logic              ext_en_i,
  input  logic              tick_i,
  input  logic              cnt_fall_i,
  input  logic              trig_fall_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cap_o,
  output logic              roll_o,
  output logic              ext_hit_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d, cap_q, cap_d;
  logic [NBYTES-1:0] cnt_bwe, cap_bwe;
  logic              active, inc, reload, capture, cnt_en, cap_en;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign cnt_bwe[g] = wr_en_i && (wr_addr_i == ADDR_W'(A_CNT_LO + g));
    assign cap_bwe[g] = wr_en_i && (wr_addr_i == ADDR_W'(A_CAP_LO + g));
  end

  always_comb begin
    active    = (mode_i == MODE_RELOAD) || (mode_i == MODE_CAPTURE);
    inc       = active && (src_ext_i ? cnt_fall_i : tick_i);
    roll_o    = inc && (cnt_q == '1);
    ext_hit_o = active && ext_en_i && trig_fall_i;
    reload    = (mode_i == MODE_RELOAD) && (roll_o || ext_hit_o);
    capture   = (mode_i == MODE_CAPTURE) && ext_hit_o;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (|cnt_bwe) begin
      for (int b = 0; b < NBYTES; b++)
        if (cnt_bwe[b]) cnt_d[b*BYTE_W +: BYTE_W] = wr_data_i;
    end else if (reload) begin
      cnt_d = cap_q;
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
    end
    cnt_en = (|cnt_bwe) | reload | inc;
  end

  always_comb begin
    cap_d = cap_q;
    if (|cap_bwe) begin
      for (int b = 0; b < NBYTES; b++)
        if (cap_bwe[b]) cap_d[b*BYTE_W +: BYTE_W] = wr_data_i;
    end else if (capture) begin
      cap_d = cnt_q;
    end
    cap_en = (|cap_bwe) | capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cap_d;
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(|cnt_bwe)) |=> $stable(cnt_q));
  // R4
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !(|cnt_bwe) && !(|cap_bwe)) |=> (cnt_q == $past(cap_q)));
  // R6
  capture_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == MODE_CAPTURE) && roll_o && !(|cnt_bwe)) |=> (cnt_q == '0));
  // R7
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !(|cap_bwe)) |=> (cap_q == $past(cnt_q)));
endmodule

// File: rtl/tmr16_capreload.sv
module tmr16_capreload
  import tmr16_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        cnt_pin_i,
  input  logic        trig_pin_i,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_addr_i,
  input  logic [7:0]  wr_data_i,
  input  logic [2:0]  rd_addr_i,
  output logic [7:0]  rd_data_o,
  output logic        irq_o
);
  logic              cnt_fall, trig_fall, roll, ext_hit, ctrl_wr;
  logic [BYTE_W-1:0] ctrl;
  logic [CNT_W-1:0]  cnt, cap;
  tmr_mode_e         mode;

  assign ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);

  tmr16_fall_det #(.STAGES(SYNC_STAGES)) u_cnt_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin_i), .fall_o(cnt_fall));

  tmr16_fall_det #(.STAGES(SYNC_STAGES)) u_trig_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(trig_pin_i), .fall_o(trig_fall));

  tmr16_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr), .wd_i(wr_data_i),
    .set_ovf_i(roll), .set_ext_i(ext_hit), .ctrl_o(ctrl), .mode_o(mode));

  tmr16_core u_core (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .src_ext_i(ctrl[B_SRC]),
    .ext_en_i(ctrl[B_EXEN]), .tick_i(tick_i), .cnt_fall_i(cnt_fall),
    .trig_fall_i(trig_fall), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cnt_o(cnt), .cap_o(cap), .roll_o(roll),
    .ext_hit_o(ext_hit));

  always_comb begin
    case (rd_addr_i)
      3'd0:    rd_data_o = ctrl;
      3'd1:    rd_data_o = cnt[7:0];
      3'd2:    rd_data_o = cnt[15:8];
      3'd3:    rd_data_o = cap[7:0];
      3'd4:    rd_data_o = cap[15:8];
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o = ctrl[B_OVF] | ctrl[B_EXTF];

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(roll | ext_hit | ctrl_wr));
endmodule

// File: tb/sim_tmr16_capreload.sv
module sim_tmr16_capreload;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b1;
  logic       cnt_pin_i = 1'b1;
  logic       trig_pin_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    tick_slow = 1'b0;
  int    tick_ph = 0;
  bit    done = 1'b0;

  logic [15:0] m_cnt, m_cap;
  logic [7:0]  m_ctrl;
  logic        t1, t2, t3, c1, c2, c3;

  always #10 clk = ~clk;

  tmr16_capreload u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_pin_i(cnt_pin_i),
    .trig_pin_i(trig_pin_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit tf, cf, inc, roll, hit;
    int mode;
    logic [15:0] n_cnt, n_cap;
    logic [7:0]  n_ctrl;
    tf = t3 & !t2;
    cf = c3 & !c2;
    if (!m_ctrl[0]) mode = 0;
    else if (m_ctrl[4] || m_ctrl[5]) mode = 1;
    else mode = m_ctrl[2] ? 3 : 2;
    inc  = (mode >= 2) && (m_ctrl[1] ? cf : tick_i);
    roll = inc && (m_cnt == 16'hFFFF);
    hit  = (mode >= 2) && m_ctrl[3] && tf;
    n_cnt = m_cnt; n_cap = m_cap; n_ctrl = m_ctrl;
    if (mode == 2 && (roll || hit)) n_cnt = m_cap;
    else if (inc) n_cnt = m_cnt + 16'd1;
    if (mode == 3 && hit) n_cap = m_cnt;
    if (wr_en_i) begin
      case (wr_addr_i)
        3'd0: n_ctrl = wr_data_i;
        3'd1: n_cnt = {m_cnt[15:8], wr_data_i};
        3'd2: n_cnt = {wr_data_i, m_cnt[7:0]};
        3'd3: n_cap = {m_cap[15:8], wr_data_i};
        3'd4: n_cap = {wr_data_i, m_cap[7:0]};
        default: ;
      endcase
    end
    if (roll) n_ctrl[7] = 1'b1;
    if (hit)  n_ctrl[6] = 1'b1;
    m_cnt = n_cnt; m_cap = n_cap; m_ctrl = n_ctrl;
    t3 = t2; t2 = t1; t1 = trig_pin_i;
    c3 = c2; c2 = c1; c1 = cnt_pin_i;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_cap = '0; m_ctrl = '0;
      t1 = 0; t2 = 0; t3 = 0; c1 = 0; c2 = 0; c3 = 0;
    end else begin
      model_step();
    end
  end

  always @(negedge clk) begin
    rd_addr_i <= (rd_addr_i >= 3'd5) ? 3'd0 : rd_addr_i + 3'd1;
    tick_ph   <= (tick_ph == 2) ? 0 : tick_ph + 1;
    tick_i    <= tick_slow ? (tick_ph == 0) : 1'b1;
  end

  always @(negedge clk) begin
    logic [7:0] exp_rd;
    #2;
    if (rst_n && !done) begin
      case (rd_addr_i)
        3'd0: exp_rd = m_ctrl;
        3'd1: exp_rd = m_cnt[7:0];
        3'd2: exp_rd = m_cnt[15:8];
        3'd3: exp_rd = m_cap[7:0];
        3'd4: exp_rd = m_cap[15:8];
        default: exp_rd = 8'h00;
      endcase
      chk(rd_data_o === exp_rd, cur_req, rd_data_o, exp_rd);
      // R11 interrupt tracks both flags
      chk(irq_o === (m_ctrl[7] | m_ctrl[6]), "R11", irq_o, m_ctrl[7] | m_ctrl[6]);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trig_pulse(input int low);
    @(negedge clk); trig_pin_i = 1'b0;
    repeat (low) @(negedge clk);
    trig_pin_i = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired during %s", cur_req);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    // R1 reset state
    chk(irq_o === 1'b0, "R1", irq_o, 0);
    idle(8);

    cur_req = "R12";
    wr(3'd1, 8'hF8); wr(3'd2, 8'hFF); wr(3'd3, 8'hF0); wr(3'd4, 8'hFF);
    wr(3'd7, 8'h55);
    idle(8);

    cur_req = "R2";
    trig_pulse(3); idle(8);

    cur_req = "R4";
    wr(3'd0, 8'h01); idle(30);
    cur_req = "R10";
    idle(5); wr(3'd0, 8'h01); idle(6);
    cur_req = "R12";
    wr(3'd2, 8'h12); wr(3'd1, 8'h34); idle(6);

    cur_req = "R3";
    tick_slow = 1'b1; idle(40);
    tick_slow = 1'b0;
    wr(3'd0, 8'h03);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); cnt_pin_i = 1'b0;
      idle(2 + (i % 3)); cnt_pin_i = 1'b1; idle(3);
    end
    idle(5);

    cur_req = "R5";
    wr(3'd0, 8'h09); trig_pulse(2); idle(10);
    trig_pulse(5); idle(10);

    cur_req = "R8";
    wr(3'd0, 8'h01); trig_pulse(2); idle(8);
    @(negedge clk); #3;
    // R8 a trigger edge with the enable clear leaves the flag down
    chk(rd_addr_i != 3'd0 || rd_data_o[6] === 1'b0, "R8", rd_data_o, 0);

    cur_req = "R6";
    wr(3'd0, 8'h04); wr(3'd3, 8'hAA); wr(3'd4, 8'h55);
    wr(3'd1, 8'hF6); wr(3'd2, 8'hFF);
    wr(3'd0, 8'h05); idle(30);

    cur_req = "R7";
    wr(3'd0, 8'h0D); trig_pulse(2); idle(7); trig_pulse(3); idle(10);

    cur_req = "R2";
    wr(3'd0, 8'h1D); trig_pulse(2); idle(8);
    wr(3'd0, 8'h2D); trig_pulse(2); idle(8);
    wr(3'd0, 8'h08); trig_pulse(2); idle(8);

    cur_req = "R9";
    wr(3'd3, 8'h00); wr(3'd4, 8'hC0);
    for (int d = 0; d < 14; d++) begin
      wr(3'd0, 8'h08);
      wr(3'd1, 8'hF8); wr(3'd2, 8'hFF);
      wr(3'd0, 8'h09);
      idle(d);
      trig_pulse(2);
      idle(14);
    end

    cur_req = "R10";
    for (int d = 0; d < 14; d++) begin
      wr(3'd0, 8'h00);
      wr(3'd1, 8'hF8); wr(3'd2, 8'hFF);
      wr(3'd0, 8'h01);
      idle(d);
      wr(3'd0, 8'h01);
      idle(4);
    end

    done = 1'b1;
    summary();
  end
endmodule